// File: doc/BRIEF.md
# Frame-Start Transmit Level Sequencer

This block sets the transmit attenuation at the start of each outgoing frame. A peak detector at the line driver output feeds two digitised comparator flags. One flag says the sensed peak lies under a low threshold, and the other says it lies over a high threshold. The block turns these flags into a saturating 3-bit attenuation code, where code n means 3·n dB of attenuation, over the range 0 to 21 dB.

Adaptation happens only in a short window at the start of each frame. That window covers the first two bit periods after a frame start. During the window the block takes exactly eight steps, placed evenly at four per bit period. After the eighth step the code is frozen and a done flag is raised. Both stay that way until the next frame start. Between the two thresholds lies a dead band in which the code does not move. The code starts each frame from the value the previous frame left.

Top module: `txlvl_seq`

## Requirements
- R1: While reset is active and after its release, `atten` is 7 (maximum attenuation) and `adapt_done` is 0.
- R2: At an adaptation instant with `flag_low`=1 and `flag_high`=0, `atten` falls by one on the next clock edge.
- R3: At an adaptation instant with `flag_high`=1, `atten` rises by one on the next clock edge. This holds whatever the value of `flag_low`, so both flags set counts as too high.
- R4: At an adaptation instant with both flags 0, `atten` is unchanged.
- R5: `atten` saturates at 0 and at 7 and never wraps. It changes by at most one per cycle.
- R6: The adaptation instants of a frame are spaced evenly, four per bit period. The first falls on the first `bit_tick` after `frame_start`, and the next three follow at intervals of SUB_CYCLES clocks. Flag values between instants have no effect.
- R7: Exactly eight adaptations are made per frame. `adapt_done` goes to 1 on the same edge as the eighth code update.
- R8: While `adapt_done` is 1, `atten` holds, whatever `bit_tick` and the flags do.
- R9: `frame_start` clears `adapt_done` on the next edge, restarts the step count, and keeps the current code. A `bit_tick` in the same cycle as `frame_start` is ignored.
- R10: After reset and before the first `frame_start`, no adaptation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking the start of a new frame |
| bit_tick | input | 1 | One-cycle pulse at the start of each bit period |
| flag_low | input | 1 | Sensed peak is below the low threshold |
| flag_high | input | 1 | Sensed peak is above the high threshold |
| atten | output | CODE_W | Attenuation code, 3 dB per step |
| adapt_done | output | 1 | Eight adaptations complete for the current frame |

## Verification
Frames are driven with flag patterns that are all low, all high, all in the dead band, both flags together, and a mixed sequence. Runs of one direction longer than the code range expose a missing clamp or a wrapping counter. The dead-band and both-flags patterns separate the hold behaviour from the priority given to the high flag. Between adaptation instants the low flag is held asserted, so an extra or misplaced instant changes the final code. Further frames restart mid-window, raise `frame_start` together with a bit strobe, and keep strobing after completion, which separates a correct count of eight from an off-by-one count and a frozen code from one that keeps adapting.

// File: rtl/txlvl_pkg.sv
package txlvl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      DIR_KEEP = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DOWN = 2'd2
   } step_dir_t;

   // Over-range wins when both comparators report
   function automatic step_dir_t pick_dir(input logic lo, input logic hi);
      if (hi)      return DIR_UP;
      else if (lo) return DIR_DOWN;
      else         return DIR_KEEP;
   endfunction

endpackage

// File: rtl/txlvl_phase.sv
module txlvl_phase #(
   parameter int STEPS_PER_BIT = 4,
   parameter int SUB_CYCLES    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bit_tick,
   output logic instant
);

   generate
      if (STEPS_PER_BIT == 1) begin : g_direct
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign instant   = bit_tick & ~clear;
      end else begin : g_divided
         localparam int SUB_W  = $clog2(SUB_CYCLES + 1);
         localparam int SLOT_W = $clog2(STEPS_PER_BIT);
         localparam logic [SUB_W-1:0]  SUB_END  = SUB_W'(SUB_CYCLES);
         localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(STEPS_PER_BIT - 1);

         logic              busy;
         logic [SUB_W-1:0]  sub_cnt;
         logic [SLOT_W-1:0] slot_cnt;
         logic              sub_hit;

         assign sub_hit = busy && (sub_cnt == SUB_END);
         assign instant = ~clear & (bit_tick | sub_hit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy     <= 1'b0;
               sub_cnt  <= '0;
               slot_cnt <= '0;
            end else if (clear) begin
               busy     <= 1'b0;
               sub_cnt  <= '0;
               slot_cnt <= '0;
            end else if (bit_tick) begin
               busy     <= 1'b1;
               sub_cnt  <= SUB_W'(1);
               slot_cnt <= SLOT_W'(1);
            end else if (sub_hit) begin
               sub_cnt  <= SUB_W'(1);
               slot_cnt <= slot_cnt + SLOT_W'(1);
               if (slot_cnt == SLOT_END) busy <= 1'b0;
            end else if (busy) begin
               sub_cnt <= sub_cnt + SUB_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/txlvl_step.sv
module txlvl_step
   import txlvl_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              lo,
   input  logic              hi,
   output logic [CODE_W-1:0] code
);

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   step_dir_t         dir;
   logic [CODE_W-1:0] code_nxt;

   always_comb begin
      dir      = pick_dir(lo, hi);
      code_nxt = code;
      if (en) begin
         unique case (dir)
            DIR_UP:   if (code != CODE_MAX) code_nxt = code + CODE_W'(1);
            DIR_DOWN: if (code != '0)       code_nxt = code - CODE_W'(1);
            default:  code_nxt = code;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= CODE_MAX;
      else        code <= code_nxt;
   end

endmodule

// File: rtl/txlvl_seq.sv
module txlvl_seq
   import txlvl_pkg::*;
#(
   parameter int CODE_W        = 3,
   parameter int ADAPT_STEPS   = 8,
   parameter int STEPS_PER_BIT = 4,
   parameter int SUB_CYCLES    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              bit_tick,
   input  logic              flag_low,
   input  logic              flag_high,
   output logic [CODE_W-1:0] atten,
   output logic              adapt_done
);

   localparam int CNT_W = $clog2(ADAPT_STEPS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADAPT_STEPS - 1);

   generate
      if (CODE_W < 1) begin : g_bad_code_w
         $error("CODE_W must be at least 1");
      end
      if (STEPS_PER_BIT < 1 || SUB_CYCLES < 1) begin : g_bad_phase
         $error("STEPS_PER_BIT and SUB_CYCLES must be at least 1");
      end
      if (ADAPT_STEPS < 1 || (ADAPT_STEPS % STEPS_PER_BIT) != 0) begin : g_bad_steps
         $error("ADAPT_STEPS must be a positive multiple of STEPS_PER_BIT");
      end
   endgenerate

   seq_state_t        state;
   logic [CNT_W-1:0]  step_cnt;
   logic              instant;
   logic              adapt;
   logic              phase_clear;

   assign phase_clear = frame_start | (state != ST_RUN);
   assign adapt       = (state == ST_RUN) & instant & ~frame_start;

   txlvl_phase #(
      .STEPS_PER_BIT (STEPS_PER_BIT),
      .SUB_CYCLES    (SUB_CYCLES)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (phase_clear),
      .bit_tick (bit_tick),
      .instant  (instant)
   );

   txlvl_step #(
      .CODE_W (CODE_W)
   ) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adapt),
      .lo    (flag_low),
      .hi    (flag_high),
      .code  (atten)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         step_cnt   <= '0;
         adapt_done <= 1'b0;
      end else if (frame_start) begin
         state      <= ST_RUN;
         step_cnt   <= '0;
         adapt_done <= 1'b0;
      end else if (adapt) begin
         step_cnt <= step_cnt + CNT_W'(1);
         if (step_cnt == CNT_LAST) begin
            state      <= ST_HOLD;
            adapt_done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/txlvl_seq_chk.sv
module txlvl_seq_chk #(
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              flag_low,
   input logic              flag_high,
   input logic [CODE_W-1:0] atten,
   input logic              adapt_done
);

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   AST_DEADBAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_low && !flag_high) |=> $stable(atten)); // R4

   AST_STEP_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      (atten != $past(atten)) |->
         ($past(flag_high) ? ({1'b0, atten} == {1'b0, $past(atten)} + 1'b1)
                           : ({1'b0, atten} + 1'b1 == {1'b0, $past(atten)}))); // R3

   AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (atten == CODE_MAX && !flag_low) |=> (atten == CODE_MAX)); // R5

   AST_CLAMP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (atten == '0 && !flag_high) |=> (atten == '0)); // R5

   AST_FROZEN_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (adapt_done && !frame_start) |=> $stable(atten)); // R8

   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !adapt_done); // R9

endmodule

bind txlvl_seq txlvl_seq_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .flag_low    (flag_low),
   .flag_high   (flag_high),
   .atten       (atten),
   .adapt_done  (adapt_done)
);

// File: tb/txlvl_seq_test.sv
module txlvl_seq_test;

   localparam int SUB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start = 1'b0;
   logic       bit_tick = 1'b0;
   logic       flag_low = 1'b1;
   logic       flag_high = 1'b0;
   logic [2:0] atten;
   logic       adapt_done;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   // flags per step {hi,lo}: step i in bits [2i+1:2i]; expected final code
   localparam int NVEC = 5;
   localparam logic [18:0] VEC [NVEC] = '{
      {16'h5555, 3'd0},   // all low: walks down, clamps at 0
      {16'hAAAA, 3'd7},   // all high: walks up, clamps at 7
      {16'h0000, 3'd7},   // dead band: no movement
      {16'h015F, 3'd4},   // both x2, low x3, none x3
      {16'h8565, 3'd1}    // mixed sequence
   };

   always #2 clk = ~clk;

   txlvl_seq #(.SUB_CYCLES(SUB)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .bit_tick    (bit_tick),
      .flag_low    (flag_low),
      .flag_high   (flag_high),
      .atten       (atten),
      .adapt_done  (adapt_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      chk(adapt_done == 1'b0, "R9 done cleared", adapt_done, 0);
      repeat (2) @(negedge clk);
   endtask

   // Present flags for one instant, then hold the low flag as junk until the next
   task automatic do_instant(input logic [1:0] f, input bit tick);
      @(negedge clk);
      {flag_high, flag_low} = f;
      bit_tick = tick;
      @(negedge clk);
      bit_tick = 1'b0;
      {flag_high, flag_low} = 2'b01;
      repeat (SUB - 2) @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(atten == 3'd7, "R1 atten in reset", atten, 7);
      chk(adapt_done == 1'b0, "R1 done in reset", adapt_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(atten == 3'd7, "R1 atten after release", atten, 7);

      // R10 strobes and low flag before any frame start
      for (int i = 0; i < 4; i++) do_instant(2'b01, 1'b1);
      chk(atten == 3'd7, "R10 no adaptation while idle", atten, 7);
      chk(adapt_done == 1'b0, "R10 done stays low", adapt_done, 0);

      // R2/R6/R7 one low step then dead band; junk low between instants ignored
      start_frame();
      chk(atten == 3'd7, "R6 no step before first strobe", atten, 7);
      do_instant(2'b01, 1'b1);
      chk(atten == 3'd6, "R2 low flag lowers code", atten, 6);
      for (int i = 1; i < 7; i++) do_instant(2'b00, (i % 4) == 0);
      chk(atten == 3'd6, "R6 junk between instants ignored", atten, 6);
      chk(adapt_done == 1'b0, "R7 not done after seven", adapt_done, 0);
      do_instant(2'b00, 1'b0);
      chk(adapt_done == 1'b1, "R7 done after eight", adapt_done, 1);

      // R8 frozen after done
      for (int i = 0; i < 8; i++) do_instant(2'b10, (i % 4) == 0);
      chk(atten == 3'd6, "R8 code frozen", atten, 6);
      chk(adapt_done == 1'b1, "R8 done held", adapt_done, 1);

      // Vector table: R2 R3 R4 R5
      for (int v = 0; v < NVEC; v++) begin
         start_frame();
         for (int i = 0; i < 8; i++) do_instant(VEC[v][3 + 2*i +: 2], (i % 4) == 0);
         chk(atten == VEC[v][2:0], "R2/R3/R4/R5 table final code", atten, VEC[v][2:0]);
         chk(adapt_done == 1'b1, "R7 table done", adapt_done, 1);
      end

      // R9 restart mid-window, with a strobe in the same cycle as frame start
      start_frame();
      for (int i = 0; i < 3; i++) do_instant(2'b10, i == 0);
      chk(atten == 3'd4, "R3 three up steps", atten, 4);
      @(negedge clk);
      frame_start = 1'b1;
      bit_tick = 1'b1;
      {flag_high, flag_low} = 2'b10;
      @(negedge clk);
      frame_start = 1'b0;
      bit_tick = 1'b0;
      {flag_high, flag_low} = 2'b01;
      chk(atten == 3'd4, "R9 strobe with frame start ignored", atten, 4);
      chk(adapt_done == 1'b0, "R9 done low after restart", adapt_done, 0);
      repeat (2) @(negedge clk);
      for (int i = 0; i < 7; i++) do_instant(2'b00, (i % 4) == 0);
      chk(atten == 3'd4, "R9 code kept across restart", atten, 4);
      chk(adapt_done == 1'b0, "R9 count restarted", adapt_done, 0);
      do_instant(2'b10, 1'b0);
      chk(atten == 3'd5, "R3 eighth step after restart", atten, 5);
      chk(adapt_done == 1'b1, "R7 done after restart frame", adapt_done, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule